// File: doc/BRIEF.md
# Radix-4 Carry-Lookahead Word Adder

This block adds two words of four radix-4 digits and a single binary carry-in. It returns a four-digit sum and one further carry-out digit, which is always 0 or 1. Each digit travels as a 2-bit code for the values 0 to 3. Digit 0, the least significant, sits in bits [1:0], digit 1 in bits [3:2], and so on upward.

Every digit position first adds its two operand digits. From that partial result it raises two binary flags. The generate flag is set when the pair overflows the digit range, and the propagate flag is set when the pair lands exactly on the largest digit value. A lookahead network forms all inter-digit carries at once from these flags and the carry-in. No carry waits on the carry of the position below it. Each binary carry is then widened into the digit value 1 and added into the partial result of the next position.

The block is purely combinational. To add wider words, instances are chained: the low bit of one instance's carry-out digit drives the carry-in of the next instance. For example, two instances form an 8-digit adder.

Top module: `q4_cla_adder`

## Requirements
- R1: For every digit position i (bits [2i+1:2i]), sum digit i equals (a_i + b_i + c_i) mod 4. Here c_i is the carry into position i: the carry-in for i = 0, otherwise 1 exactly when the lower i digits of both operands plus the carry-in reach 4^i.
- R2: When a_i + b_i is greater than 3, the carry out of position i is 1, whatever the carry into it.
- R3: When a_i + b_i equals exactly 3, the carry out of position i equals the carry into position i. A carry-in of 1 therefore passes through any run of such positions.
- R4: When a_i + b_i is less than 3, the carry out of position i is 0.
- R5: The five-digit value {cout_o, sum_o}, read in base 4, equals the integer a_i + b_i + cin_i.
- R6: The carry-out digit is only ever 0 or 1, so cout_o[1] is always 0.
- R7: Two instances chained low-to-high through cout_o[0] into cin_i form an 8-digit adder. With carry-in 0, adding 31020023 and 33212131 in base 4 gives 130232220 in base 4.
- R8: With every digit of a_i equal to 3, b_i equal to 0 and cin_i equal to 1, the carry passes through all positions: sum_o is 0 and cout_o is the digit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand, four 2-bit digits, least significant digit in [1:0] |
| b_i | input | 8 | Second operand, same packing as a_i |
| cin_i | input | 1 | Binary carry into digit 0 |
| sum_o | output | 8 | Four sum digits, same packing as the operands |
| cout_o | output | 2 | Carry-out digit, value 0 or 1 |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as its stimulus, zero register stages later. The bench changes the operands on a falling clock edge and samples the outputs one nanosecond later, well before the next rising edge. Each sample therefore reflects only the vector just applied. The per-position carries in R2 to R4 are recovered at the ports: each carry is read back from the next sum digit, or from the carry-out digit at the top position.

// File: rtl/q4_add_pkg.sv
package q4_add_pkg;
  localparam int unsigned DIGIT_W = 2;
  localparam int unsigned RADIX   = 1 << DIGIT_W;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DIGIT_MAX = digit_t'(RADIX - 1);
endpackage

// File: rtl/q4_digit_ha.sv
// Digit half-adder: two digits in, one digit and an overflow bit out.
module q4_digit_ha
  import q4_add_pkg::*;
(
  input  digit_t x_i,
  input  digit_t y_i,
  output digit_t s_o,
  output logic   ovf_o
);
  logic [DIGIT_W:0] wide;

  assign wide  = {1'b0, x_i} + {1'b0, y_i};
  assign s_o   = wide[DIGIT_W-1:0];
  assign ovf_o = wide[DIGIT_W];
endmodule

// File: rtl/q4_digit_gp.sv
// First stage of a digit position: partial sum plus generate and propagate.
module q4_digit_gp
  import q4_add_pkg::*;
(
  input  digit_t a_i,
  input  digit_t b_i,
  output digit_t psum_o,
  output logic   gen_o,
  output logic   prop_o
);
  q4_digit_ha u_ha (
    .x_i   (a_i),
    .y_i   (b_i),
    .s_o   (psum_o),
    .ovf_o (gen_o)
  );

  // An exact hit on the top digit value passes an incoming carry on.
  assign prop_o = ~gen_o & (psum_o == DIGIT_MAX);
endmodule

// File: rtl/q4_lookahead.sv
// Parallel carry network: every carry is built from flags and carry-in only.
module q4_lookahead #(
  parameter int unsigned DIGITS = 4
) (
  input  logic [DIGITS-1:0] gen_i,
  input  logic [DIGITS-1:0] prop_i,
  input  logic              cin_i,
  output logic [DIGITS:0]   carry_o
);
  always_comb begin
    logic acc;
    logic run;
    carry_o    = '0;
    carry_o[0] = cin_i;
    for (int i = 0; i < DIGITS; i++) begin
      acc = gen_i[i];
      // carry-in surviving all positions 0..i
      run = cin_i;
      for (int j = 0; j <= i; j++) run = run & prop_i[j];
      acc = acc | run;
      // generate at k surviving positions k+1..i
      for (int k = 0; k < i; k++) begin
        run = gen_i[k];
        for (int j = k + 1; j <= i; j++) run = run & prop_i[j];
        acc = acc | run;
      end
      carry_o[i+1] = acc;
    end
  end
endmodule

// File: rtl/q4_digit_sum.sv
// Second stage of a digit position: binary carry widened to a digit and added.
module q4_digit_sum
  import q4_add_pkg::*;
(
  input  digit_t psum_i,
  input  logic   cy_i,
  output digit_t s_o
);
  digit_t cy_digit;

  assign cy_digit = {{(DIGIT_W-1){1'b0}}, cy_i};
  // Overflow here is already accounted for by the propagate path.
  assign s_o      = psum_i + cy_digit;
endmodule

// File: rtl/q4_cla_adder.sv
module q4_cla_adder
  import q4_add_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned WORD_W = DIGITS * DIGIT_W
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              cin_i,
  output logic [WORD_W-1:0] sum_o,
  output digit_t            cout_o
);
  digit_t [DIGITS-1:0] psum_w;
  logic   [DIGITS-1:0] gen_w;
  logic   [DIGITS-1:0] prop_w;
  logic   [DIGITS:0]   carry_w;

  for (genvar d = 0; d < DIGITS; d++) begin : g_front
    q4_digit_gp u_gp (
      .a_i    (a_i[d*DIGIT_W +: DIGIT_W]),
      .b_i    (b_i[d*DIGIT_W +: DIGIT_W]),
      .psum_o (psum_w[d]),
      .gen_o  (gen_w[d]),
      .prop_o (prop_w[d])
    );
  end

  q4_lookahead #(.DIGITS(DIGITS)) u_cla (
    .gen_i   (gen_w),
    .prop_i  (prop_w),
    .cin_i   (cin_i),
    .carry_o (carry_w)
  );

  for (genvar d = 0; d < DIGITS; d++) begin : g_back
    q4_digit_sum u_sum (
      .psum_i (psum_w[d]),
      .cy_i   (carry_w[d]),
      .s_o    (sum_o[d*DIGIT_W +: DIGIT_W])
    );
  end

  assign cout_o = {{(DIGIT_W-1){1'b0}}, carry_w[DIGITS]};
endmodule

// File: rtl/q4_cla_check.sv
module q4_cla_check
  import q4_add_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned WORD_W = DIGITS * DIGIT_W
) (
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic              cin_i,
  input logic [WORD_W-1:0] sum_o,
  input digit_t            cout_o,
  input logic [DIGITS:0]   carry_i
);
  always_comb begin
    int unsigned pair;
    logic [WORD_W+DIGIT_W-1:0] lhs;
    logic [WORD_W+DIGIT_W-1:0] rhs;
    if (!$isunknown({a_i, b_i, cin_i})) begin
      for (int i = 0; i < DIGITS; i++) begin
        pair = int'(a_i[i*DIGIT_W +: DIGIT_W]) + int'(b_i[i*DIGIT_W +: DIGIT_W]);
        if (pair > int'(DIGIT_MAX))
          p_gen_sets_carry_r2: assert (carry_i[i+1]);
        if (pair == int'(DIGIT_MAX))
          p_prop_passes_carry_r3: assert (carry_i[i+1] == carry_i[i]);
        if (pair < int'(DIGIT_MAX))
          p_kill_clears_carry_r4: assert (!carry_i[i+1]);
        p_digit_value_r1: assert (int'(sum_o[i*DIGIT_W +: DIGIT_W]) ==
                                  ((pair + int'(carry_i[i])) % int'(RADIX)));
      end
      lhs = {cout_o, sum_o};
      rhs = {{DIGIT_W{1'b0}}, a_i} + {{DIGIT_W{1'b0}}, b_i} +
            {{(WORD_W+DIGIT_W-1){1'b0}}, cin_i};
      p_word_value_r5: assert (lhs == rhs);
      p_cout_digit_r6: assert (cout_o[DIGIT_W-1:1] == '0);
    end
  end
endmodule

bind q4_cla_adder q4_cla_check #(.DIGITS(DIGITS)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .carry_i (carry_w)
);

// File: tb/sim_q4_cla_adder.sv
`timescale 1ns/1ps
module sim_q4_cla_adder;
  localparam int WORD_W = 8;
  localparam int SPAN   = 1 << WORD_W;
  localparam int WD_LIM = 180000;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [7:0] a, b, sum;
  logic       ci;
  logic [1:0] cout;

  logic [7:0] lo_a, lo_b, lo_s, hi_a, hi_b, hi_s;
  logic [1:0] lo_co, hi_co;

  q4_cla_adder u0 (.a_i(a), .b_i(b), .cin_i(ci), .sum_o(sum), .cout_o(cout));
  q4_cla_adder u1 (.a_i(lo_a), .b_i(lo_b), .cin_i(1'b0), .sum_o(lo_s), .cout_o(lo_co));
  q4_cla_adder u2 (.a_i(hi_a), .b_i(hi_b), .cin_i(lo_co[0]), .sum_o(hi_s), .cout_o(hi_co));

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s a=%0h b=%0h cin=%0d got=%0d exp=%0d", req, a, b, ci, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check_vec(input int av, input int bv, input int cv);
    int dc [0:4];
    int ai, bi, si, ref_c, got_full, exp_full, m;
    @(negedge clk);
    a = av[7:0]; b = bv[7:0]; ci = cv[0];
    #1;
    exp_full = av + bv + cv;
    got_full = int'({cout, sum});
    chk(got_full == exp_full, "R5", got_full, exp_full);
    chk(cout[1] == 1'b0, "R6", int'(cout), 1);
    dc[0] = cv;
    for (int i = 0; i < 4; i++) begin
      if (i < 3)
        dc[i+1] = (int'((sum >> (2*(i+1))) & 8'h3) - ((av >> (2*(i+1))) & 3)
                   - ((bv >> (2*(i+1))) & 3)) & 3;
      else
        dc[i+1] = int'(cout);
    end
    for (int i = 0; i < 4; i++) begin
      ai = (av >> (2*i)) & 3;
      bi = (bv >> (2*i)) & 3;
      si = int'((sum >> (2*i)) & 8'h3);
      m  = 1 << (2*i);
      ref_c = ((av % m) + (bv % m) + cv) >= m ? 1 : 0;
      if (i == 0) ref_c = cv;
      chk(si == ((ai + bi + ref_c) % 4), "R1", si, (ai + bi + ref_c) % 4);
      if (ai + bi > 3)  chk(dc[i+1] == 1, "R2", dc[i+1], 1);
      if (ai + bi == 3) chk(dc[i+1] == dc[i], "R3", dc[i+1], dc[i]);
      if (ai + bi < 3)  chk(dc[i+1] == 0, "R4", dc[i+1], 0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= WD_LIM) begin
        bad++; total++;
        $display("FAIL watchdog got=%0d exp=%0d", cycles, WD_LIM);
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; ci = 1'b0;
    lo_a = '0; lo_b = '0; hi_a = '0; hi_b = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R5: zero operands during reset give a zero result
    chk(sum == 8'h00 && cout == 2'd0, "R5", int'({cout, sum}), 0);
    rst_n = 1'b1;

    // R8: full propagate chain with carry-in
    check_vec(8'hFF, 8'h00, 1);
    chk(sum == 8'h00, "R8", int'(sum), 0);
    chk(cout == 2'd1, "R8", int'(cout), 1);

    // R7: chained 8-digit known case
    @(negedge clk);
    lo_a = 8'h0B; hi_a = 8'hD2;
    lo_b = 8'h9D; hi_b = 8'hF9;
    #1;
    chk(lo_s == 8'hA8, "R7", int'(lo_s), 'hA8);
    chk(hi_s == 8'hCB, "R7", int'(hi_s), 'hCB);
    chk(hi_co == 2'd1, "R7", int'(hi_co), 1);
    chk(int'({hi_co, hi_s, lo_s}) == (32'hD20B + 32'hF99D),
        "R7", int'({hi_co, hi_s, lo_s}), 32'hD20B + 32'hF99D);

    // R1..R6: exhaustive sweep of operands and carry-in
    for (int cv = 0; cv < 2; cv++)
      for (int av = 0; av < SPAN; av++)
        for (int bv = 0; bv < SPAN; bv++)
          check_vec(av, bv, cv);

    finish_run();
  end
endmodule